// File: doc/BRIEF.md
# Down-Counting Reload Timer with Shared Reload/Count Address

This block is a parameterised down-counter with a reload register and one control word. A register bus sees two word addresses. One is the control word. The other is an address shared by two registers and split by access direction. A write there loads the reload register and leaves the running count untouched. A read there returns the live count. The reload register itself can never be read back. For that reason, software cannot do a read-modify-write on the shared address: the value it reads is the count, not the reload value.

While the enable bit is set, a start trigger copies the reload value into the counter and marks it running. Each count tick then lowers the count by one. A tick that finds the count at zero is an underflow. An underflow sets a sticky flag and then acts by mode: in reload mode it refills the counter from the reload register, and in one-shot mode it parks the counter at zero. The interrupt output is the flag gated by an interrupt-enable bit.

Top module: `alias_reload_timer`

## Requirements
- R1: A write to the shared address with all byte enables set stores the data in the reload register and leaves the count unchanged.
- R2: A read of the shared address returns the current count. Read data appears on `bus_rdata` one clock after the read cycle and holds until the next read.
- R3: A write to the shared address with any byte enable clear is dropped. The reload register keeps its old value.
- R4: With the enable bit (control bit 0) set, a start trigger loads the count from the reload register. A trigger in the same cycle as a tick wins over the tick.
- R5: With the enable bit clear, start triggers and ticks are ignored, and the count holds its value.
- R6: While running and enabled, each tick with a non-zero count lowers the count by exactly one.
- R7: A tick at count zero sets the sticky underflow flag (control bit 3). In reload mode (control bit 1 = 1) the same tick reloads the count from the reload register.
- R8: In one-shot mode (control bit 1 = 0), underflow leaves the count at zero and stops it. Later ticks leave it at zero until the next trigger.
- R9: Writing 0 to control bit 3 clears the flag. Writing 1 there has no effect. A control write needs byte enable 0, and bits 0 to 2 take the written value.
- R10: `irq` equals the flag ANDed with the interrupt-enable bit (control bit 2).
- R11: A reload write made while the timer runs is kept, and the next reload uses the new value.
- R12: After reset, the control word reads 0, the count reads 0, and `irq` is low.
- R13: Setting the enable bit again after it was cleared resumes counting from the held count, with no trigger needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address (control word or shared address) |
| bus_be | input | CNT_W/8 | Byte enables for a write |
| bus_wdata | input | CNT_W | Write data |
| bus_rdata | output | CNT_W | Read data, one clock after the read |
| start_trig | input | 1 | Start trigger, one cycle per event |
| count_tick | input | 1 | Count-enable tick |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that every bus access lasts one cycle. They also assume that, before any trigger starts the counter, the reload register has been written once with a full word. The reload register has no reset value, so until then its contents are undefined. The stimulus writes the reload value while the timer is disabled before every first trigger. It keeps `count_tick` low during read cycles, so each expected count is fixed when the read is issued. It issues partial-byte writes only after a full word has set the reload register.

// File: rtl/rtmr_pkg.sv
package rtmr_pkg;
   localparam int CTL_EN   = 0;
   localparam int CTL_MODE = 1;
   localparam int CTL_IEN  = 2;
   localparam int CTL_FLAG = 3;
   localparam int CTL_BITS = 4;

   typedef struct packed {
      logic flag;
      logic ien;
      logic mode;
      logic en;
   } ctl_t;
endpackage

// File: rtl/rtmr_regfile.sv
module rtmr_regfile
   import rtmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 0,
   parameter int ALIAS_ADDR = 1,
   localparam int BE_W      = CNT_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [BE_W-1:0]   be_i,
   input  logic [CNT_W-1:0]  wdata_i,
   input  logic              uf_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic              reload_we_o,
   output ctl_t              ctl_o
);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_ALS = ADDR_W'(ALIAS_ADDR);

   logic             ctl_we;
   logic             alias_hit;
   logic [CNT_W-1:0] reload_q;
   ctl_t             ctl_q;

   assign alias_hit   = wr_i && (addr_i == A_ALS);
   assign reload_we_o = alias_hit && (&be_i);
   assign ctl_we      = wr_i && (addr_i == A_CTL) && be_i[0];

   // reload holder: no reset, contents undefined until first full write
   always_ff @(posedge clk) begin
      if (reload_we_o) reload_q <= wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= '0;
      end else begin
         if (ctl_we) begin
            ctl_q.en   <= wdata_i[CTL_EN];
            ctl_q.mode <= wdata_i[CTL_MODE];
            ctl_q.ien  <= wdata_i[CTL_IEN];
         end
         if (uf_i)
            ctl_q.flag <= 1'b1;
         else if (ctl_we && !wdata_i[CTL_FLAG])
            ctl_q.flag <= 1'b0;
      end
   end

   assign reload_o = reload_q;
   assign ctl_o    = ctl_q;

   a_r3_partial_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (alias_hit && !(&be_i)) |=> $stable(reload_o));
   a_r7_underflow_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      uf_i |=> ctl_o.flag);
   a_r9_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl_o.flag && !(ctl_we && !wdata_i[CTL_FLAG])) |=> ctl_o.flag);
endmodule

// File: rtl/rtmr_downcnt.sv
module rtmr_downcnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             reload_mode_i,
   input  logic             trig_i,
   input  logic             tick_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             uf_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             act_q;
   logic             go_trig;
   logic             go_tick;
   logic             at_zero;

   assign go_trig = en_i && trig_i;
   assign go_tick = en_i && act_q && tick_i && !go_trig;
   assign at_zero = (cnt_q == '0);
   assign uf_o    = go_tick && at_zero;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         act_q <= 1'b0;
      end else if (go_trig) begin
         cnt_q <= reload_i;
         act_q <= 1'b1;
      end else if (go_tick) begin
         if (!at_zero)
            cnt_q <= cnt_q - 1'b1;
         else if (reload_mode_i)
            cnt_q <= reload_i;
         else
            act_q <= 1'b0;
      end
   end

   assign cnt_o = cnt_q;

   a_r4_trigger_loads: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && trig_i) |=> (cnt_o == $past(reload_i)));
   a_r5_disabled_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> $stable(cnt_o));
   a_r6_single_step: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && act_q && tick_i && !trig_i && cnt_o != '0) |=> (cnt_o == $past(cnt_o) - 1'b1));
   a_r8_oneshot_parks: assert property (@(posedge clk) disable iff (!rst_n)
      (uf_o && !reload_mode_i) |=> (cnt_o == '0));
endmodule

// File: rtl/rtmr_rdport.sv
module rtmr_rdport
   import rtmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 0,
   parameter int ALIAS_ADDR = 1,
   parameter int READ_LAT   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  ctl_t              ctl_i,
   output logic [CNT_W-1:0]  rdata_o
);
   localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(CTRL_ADDR);
   localparam logic [ADDR_W-1:0] A_ALS = ADDR_W'(ALIAS_ADDR);

   logic [CNT_W-1:0] sel_val;

   always_comb begin
      if (addr_i == A_ALS)
         sel_val = cnt_i;
      else if (addr_i == A_CTL)
         sel_val = {{(CNT_W-CTL_BITS){1'b0}}, ctl_i};
      else
         sel_val = '0;
   end

   generate
      if (READ_LAT == 0) begin : g_comb
         assign rdata_o = rd_i ? sel_val : '0;
      end else begin : g_reg
         logic [CNT_W-1:0] rd_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)    rd_q <= '0;
            else if (rd_i) rd_q <= sel_val;
         end
         assign rdata_o = rd_q;
      end
   endgenerate
endmodule

// File: rtl/alias_reload_timer.sv
module alias_reload_timer
   import rtmr_pkg::*;
#(
   parameter int CNT_W      = 16,
   parameter int ADDR_W     = 2,
   parameter int CTRL_ADDR  = 0,
   parameter int ALIAS_ADDR = 1,
   parameter int READ_LAT   = 1,
   localparam int BE_W      = CNT_W / 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BE_W-1:0]   bus_be,
   input  logic [CNT_W-1:0]  bus_wdata,
   output logic [CNT_W-1:0]  bus_rdata,
   input  logic              start_trig,
   input  logic              count_tick,
   output logic              irq
);
   generate
      if (CNT_W < 8 || (CNT_W % 8) != 0) begin : g_bad_width
         $error("CNT_W must be a non-zero multiple of 8");
      end
      if (CTRL_ADDR == ALIAS_ADDR) begin : g_bad_map
         $error("control and shared address must differ");
      end
      if (CTRL_ADDR >= (1 << ADDR_W) || ALIAS_ADDR >= (1 << ADDR_W)) begin : g_bad_addr
         $error("address does not fit ADDR_W");
      end
      if (READ_LAT != 0 && READ_LAT != 1) begin : g_bad_lat
         $error("READ_LAT must be 0 or 1");
      end
   endgenerate

   logic             wr_cyc;
   logic             rd_cyc;
   logic [CNT_W-1:0] reload_val;
   logic             reload_we;
   logic [CNT_W-1:0] cnt_val;
   logic             uf;
   ctl_t             ctl;

   assign wr_cyc = bus_sel && bus_wr;
   assign rd_cyc = bus_sel && !bus_wr;

   rtmr_regfile #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ALIAS_ADDR(ALIAS_ADDR)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_cyc), .addr_i(bus_addr), .be_i(bus_be),
      .wdata_i(bus_wdata), .uf_i(uf), .reload_o(reload_val), .reload_we_o(reload_we),
      .ctl_o(ctl)
   );

   rtmr_downcnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .en_i(ctl.en), .reload_mode_i(ctl.mode),
      .trig_i(start_trig), .tick_i(count_tick), .reload_i(reload_val),
      .cnt_o(cnt_val), .uf_o(uf)
   );

   rtmr_rdport #(
      .CNT_W(CNT_W), .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .ALIAS_ADDR(ALIAS_ADDR),
      .READ_LAT(READ_LAT)
   ) u_rd (
      .clk(clk), .rst_n(rst_n), .rd_i(rd_cyc), .addr_i(bus_addr), .cnt_i(cnt_val),
      .ctl_i(ctl), .rdata_o(bus_rdata)
   );

   assign irq = ctl.flag && ctl.ien;

   a_r1_alias_write_keeps_count: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_we && !start_trig && !count_tick) |=> $stable(cnt_val));
   a_r12_irq_low_without_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl.flag && !uf) |=> !irq);
endmodule

// File: tb/tb_alias_reload_timer.sv
module tb_alias_reload_timer;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_sel = 1'b0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_addr = '0;
   logic [1:0]    bus_be = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic          start_trig = 1'b0;
   logic          count_tick = 1'b0;
   logic          irq;

   always #2.5 clk = ~clk;

   alias_reload_timer dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .start_trig(start_trig), .count_tick(count_tick), .irq(irq)
   );

   typedef struct {
      logic [DW-1:0] exp;
      string         tag;
   } sb_item_t;

   sb_item_t sb_q[$];
   int       n_chk = 0;
   int       n_fail = 0;
   logic     rd_fired = 1'b0;
   bit       done = 1'b0;

   localparam logic [1:0] A_CTL = 2'd0;
   localparam logic [1:0] A_ALS = 2'd1;

   task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%04h expected 0x%04h", tag, act, exp);
      end
   endtask

   // monitor: compares read data one clock after each read cycle
   always @(posedge clk) rd_fired <= bus_sel && !bus_wr;
   always @(negedge clk) begin
      if (rd_fired) begin
         if (sb_q.size() == 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: unexpected read data 0x%04h expected none", bus_rdata);
         end else begin
            sb_item_t it;
            it = sb_q.pop_front();
            chk(it.tag, bus_rdata, it.exp);
         end
      end
   end

   task automatic bus_write(logic [1:0] a, logic [DW-1:0] d, logic [1:0] be);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
   endtask

   task automatic bus_read(logic [1:0] a, logic [DW-1:0] exp, string tag);
      sb_item_t it;
      it.exp = exp; it.tag = tag;
      sb_q.push_back(it);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      @(negedge clk);
   endtask

   task automatic trig();
      start_trig = 1'b1;
      @(negedge clk);
      start_trig = 1'b0;
   endtask

   task automatic ticks(int n);
      count_tick = 1'b1;
      repeat (n) @(negedge clk);
      count_tick = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         if (sb_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb_q.size());
         end
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12 reset state
      bus_read(A_CTL, 16'h0000, "R12 ctrl after reset");
      bus_read(A_ALS, 16'h0000, "R12 count after reset");
      chk("R12 irq after reset", {15'd0, irq}, 16'd0);

      // R1/R2: reload write while disabled, read returns count
      bus_write(A_ALS, 16'h0005, 2'b11);
      bus_read(A_ALS, 16'h0000, "R2 read shows count not reload");
      // R5: trigger while disabled ignored
      trig();
      bus_read(A_ALS, 16'h0000, "R5 trigger ignored when disabled");

      // R4: enable reload mode + irq, trigger
      bus_write(A_CTL, 16'h0007, 2'b01);
      trig();
      bus_read(A_ALS, 16'h0005, "R4 trigger loads reload value");
      // R6: three ticks
      ticks(3);
      bus_read(A_ALS, 16'h0002, "R6 decrement per tick");
      // R11 write while running, then R3 partial write dropped
      bus_write(A_ALS, 16'h0009, 2'b11);
      bus_write(A_ALS, 16'h00AA, 2'b01);
      bus_write(A_ALS, 16'hBB00, 2'b10);
      bus_read(A_ALS, 16'h0002, "R1 alias write leaves count");
      ticks(2);
      bus_read(A_ALS, 16'h0000, "R6 count reaches zero");
      chk("R7 no flag before underflow", {15'd0, irq}, 16'd0);
      ticks(1);
      bus_read(A_ALS, 16'h0009, "R7 R11 R3 underflow reloads newest full write");
      bus_read(A_CTL, 16'h000F, "R7 flag set on underflow");
      chk("R10 irq with flag and enable", {15'd0, irq}, 16'd1);

      // R9 flag write-1 no effect, R10 gating
      bus_write(A_CTL, 16'h000F, 2'b01);
      bus_read(A_CTL, 16'h000F, "R9 writing one keeps flag");
      bus_write(A_CTL, 16'h000B, 2'b01);
      chk("R10 irq masked by ien", {15'd0, irq}, 16'd0);
      bus_write(A_CTL, 16'h000F, 2'b01);
      chk("R10 irq back when ien set", {15'd0, irq}, 16'd1);
      bus_write(A_CTL, 16'h0007, 2'b01);
      bus_read(A_CTL, 16'h0007, "R9 writing zero clears flag");
      chk("R10 irq low after clear", {15'd0, irq}, 16'd0);

      // R5 halt, R13 resume
      ticks(4);
      bus_read(A_ALS, 16'h0005, "R6 counting after reload");
      bus_write(A_CTL, 16'h0006, 2'b01);
      ticks(3);
      trig();
      bus_read(A_ALS, 16'h0005, "R5 disabled holds count");
      bus_write(A_CTL, 16'h0007, 2'b01);
      ticks(1);
      bus_read(A_ALS, 16'h0004, "R13 resume from held count");

      // R8 one-shot
      bus_write(A_CTL, 16'h0000, 2'b01);
      bus_write(A_ALS, 16'h0003, 2'b11);
      bus_write(A_CTL, 16'h0005, 2'b01);
      trig();
      bus_read(A_ALS, 16'h0003, "R4 trigger in one-shot mode");
      ticks(4);
      bus_read(A_ALS, 16'h0000, "R8 one-shot parks at zero");
      bus_read(A_CTL, 16'h000D, "R8 R7 one-shot flag set");
      ticks(2);
      bus_read(A_ALS, 16'h0000, "R8 stays stopped on ticks");
      trig();
      bus_read(A_ALS, 16'h0003, "R8 R4 retrigger restarts");

      repeat (2) @(negedge clk);
      finish_run();
   end
endmodule